// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

This block is a tiny single-issue accumulator machine with 4-bit data. Each instruction is one byte. The upper nibble selects one of sixteen operations. The lower nibble is the only operand field. Depending on the operation, that field is either a literal value or the index of a register. All architectural state lives in a sixteen-entry file of nibble registers:

| Index | Register | Role |
|---|---|---|
| 0 | ACC | accumulator |
| 1 | STS | status flags |
| 2 | LOS | selects the load/store register |
| 3 | ADR | address base and jump target |
| 4 | IP | instruction pointer |
| 5 to 15 | general purpose | |

Instruction memory and a sixteen-nibble data memory sit outside the core. Both are read combinationally, so one instruction retires on every clock while the core runs.

Software places a program at address 0 and raises `start` for one cycle. The core then executes until it reaches a return instruction. At that point it freezes and raises `halted`, with the instruction's literal on `ret_val`. Only a reset brings it back to idle.

Top module: `nibble_accum_core`

## Requirements
- R1: After reset, `busy`, `halted` and `dmem_we` are low and `imem_addr` is 0. All registers hold 0, so LOS points at ACC. Nothing executes until `start` is seen high at a clock edge.
- R2: Instruction bits [7:4] are the opcode and bits [3:0] are the parameter. While running, one instruction executes on every clock. IP advances by one, wrapping from 15 to 0, unless the instruction jumps or writes IP.
- R3: Opcode 0 stops execution and drives its parameter on `ret_val` with `halted` high. This state is permanent until reset: `start` is ignored, IP does not advance and no data write occurs.
- R4: Opcodes 1 to 4 write ACC with the result modulo 16 of ACC plus, minus, times or divided by the selected register. Division by zero yields 15 with the carry flag set.
- R5: Opcodes 5, 6 and 7 write ACC with the bitwise AND, OR or XOR of ACC and the selected register.
- R6: Flag word layout: bit 0 = result is zero; bit 1 = carry; bit 2 = result bit 3; bit 3 = signed overflow.
  - Carry means carry out for add, borrow for subtract, a nonzero high nibble for multiply, and divide by zero for divide.
  - Signed overflow applies to add and subtract only.
  - Moves, loads and logic operations clear bits 1 and 3.
- R7: Opcode 8 leaves ACC unchanged and sets STS as follows: bit 0 = ACC is zero; bit 1 = ACC < register; bit 2 = ACC > register; bit 3 = ACC equals register. All comparisons are unsigned.
- R8: Opcode 9 writes the literal into register[LOS]. Opcode A writes data memory at (ADR + literal) mod 16 into register[LOS]. Opcode B writes register[LOS] to data memory at that address without touching STS.
- R9: Opcode C copies the selected register into ACC. Opcode D copies ACC into the selected register. Opcode F zeroes the selected register, except that zeroing STS leaves it at 0001 (zero flag only). Each sets the flags from the value written.
- R10: Opcode E loads IP from ADR when (literal AND STS) is nonzero, and otherwise falls through. Zeroing STS and then executing opcode E with literal 15 always jumps.
- R11: An explicit write to STS (loads, opcode D) replaces the flag update of the same instruction. An explicit write to IP replaces its increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin execution at IP 0 when idle |
| imem_addr | output | 4 | instruction fetch address (IP) |
| imem_data | input | 8 | instruction byte at `imem_addr` |
| dmem_addr | output | 4 | data address, ADR + literal |
| dmem_rdata | input | 4 | data nibble at `dmem_addr` |
| dmem_we | output | 1 | data write strobe |
| dmem_wdata | output | 4 | data to write, register[LOS] |
| busy | output | 1 | core is executing |
| halted | output | 1 | return instruction reached |
| ret_val | output | 4 | literal of the return instruction |

## Verification
The in-line assertions watch several behaviours on every cycle:
- that a halt is permanent and the returned value stays frozen;
- that data writes occur only while running;
- that arithmetic and compare instructions step IP by exactly one;
- that compare leaves ACC alone;
- that a taken jump lands on ADR.

Arithmetic values, the flag encodings and indirection through LOS can only be shown by the bench's directed programs. The same holds for address wrap, for the priority of explicit STS and IP writes, and for the zero-then-jump idiom. Each of those programs leaves its results in data memory and in the returned value.

// File: rtl/nibble_accum_core.sv
module nibble_accum_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic [3:0] imem_addr,
  input  logic [7:0] imem_data,
  output logic [3:0] dmem_addr,
  input  logic [3:0] dmem_rdata,
  output logic       dmem_we,
  output logic [3:0] dmem_wdata,
  output logic       busy,
  output logic       halted,
  output logic [3:0] ret_val
);

  localparam int NREG = 16;
  localparam logic [3:0] IX_ACC = 4'd0, IX_STS = 4'd1, IX_LOS = 4'd2, IX_ADR = 4'd3, IX_IP = 4'd4;
  localparam logic [3:0] OP_RET = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_MUL = 4'h3,
                         OP_DIV = 4'h4, OP_AND = 4'h5, OP_ORR = 4'h6, OP_XOR = 4'h7,
                         OP_CMP = 4'h8, OP_LDI = 4'h9, OP_LDM = 4'hA, OP_STO = 4'hB,
                         OP_CPA = 4'hC, OP_CPR = 4'hD, OP_JMP = 4'hE, OP_CLR = 4'hF;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HALT} state_t;

  state_t     state;
  logic [3:0] rf [NREG];
  logic [3:0] ret_q;

  wire [3:0] op  = imem_data[7:4];
  wire [3:0] prm = imem_data[3:0];
  wire [3:0] acc = rf[IX_ACC];
  wire [3:0] sts = rf[IX_STS];
  wire [3:0] los = rf[IX_LOS];
  wire [3:0] adr = rf[IX_ADR];
  wire [3:0] ip  = rf[IX_IP];
  wire [3:0] rsel = rf[prm];
  wire       run = (state == S_RUN);

  function automatic logic [3:0] mkflags(input logic [3:0] v, input logic c, input logic o);
    return {o, v[3], c, (v == 4'd0)};
  endfunction

  // arithmetic and logic unit
  logic [3:0] alu_res;
  logic       alu_c, alu_v;
  logic [4:0] sum;
  logic [7:0] prod;
  logic [3:0] diff;

  assign sum  = {1'b0, acc} + {1'b0, rsel};
  assign diff = acc - rsel;
  assign prod = {4'd0, acc} * {4'd0, rsel};

  always_comb begin
    alu_res = acc;
    alu_c   = 1'b0;
    alu_v   = 1'b0;
    case (op)
      OP_ADD: begin
        alu_res = sum[3:0];
        alu_c   = sum[4];
        alu_v   = (acc[3] == rsel[3]) && (sum[3] != acc[3]);
      end
      OP_SUB: begin
        alu_res = diff;
        alu_c   = (acc < rsel);
        alu_v   = (acc[3] != rsel[3]) && (diff[3] != acc[3]);
      end
      OP_MUL: begin
        alu_res = prod[3:0];
        alu_c   = |prod[7:4];
      end
      OP_DIV: begin
        if (rsel == 4'd0) begin
          alu_res = 4'hF;
          alu_c   = 1'b1;
        end else begin
          alu_res = acc / rsel;
        end
      end
      OP_AND: alu_res = acc & rsel;
      OP_ORR: alu_res = acc | rsel;
      OP_XOR: alu_res = acc ^ rsel;
      default: ;
    endcase
  end

  // decode: register write, flag update, branch
  logic       wr_en, fl_en, jump;
  logic [3:0] wr_idx, wr_val, fl_val;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = prm;
    wr_val = 4'd0;
    fl_en  = 1'b0;
    fl_val = 4'd0;
    jump   = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_AND, OP_ORR, OP_XOR: begin
        wr_en  = 1'b1;
        wr_idx = IX_ACC;
        wr_val = alu_res;
        fl_en  = 1'b1;
        fl_val = mkflags(alu_res, alu_c, alu_v);
      end
      OP_CMP: begin
        fl_en  = 1'b1;
        fl_val = {acc == rsel, acc > rsel, acc < rsel, acc == 4'd0};
      end
      OP_LDI: begin
        wr_en  = 1'b1;
        wr_idx = los;
        wr_val = prm;
        fl_en  = 1'b1;
        fl_val = mkflags(prm, 1'b0, 1'b0);
      end
      OP_LDM: begin
        wr_en  = 1'b1;
        wr_idx = los;
        wr_val = dmem_rdata;
        fl_en  = 1'b1;
        fl_val = mkflags(dmem_rdata, 1'b0, 1'b0);
      end
      OP_CPA: begin
        wr_en  = 1'b1;
        wr_idx = IX_ACC;
        wr_val = rsel;
        fl_en  = 1'b1;
        fl_val = mkflags(rsel, 1'b0, 1'b0);
      end
      OP_CPR: begin
        wr_en  = 1'b1;
        wr_val = acc;
        fl_en  = 1'b1;
        fl_val = mkflags(acc, 1'b0, 1'b0);
      end
      OP_JMP: jump = |(prm & sts);
      OP_CLR: begin
        wr_en  = 1'b1;
        wr_val = (prm == IX_STS) ? 4'b0001 : 4'd0;
        fl_en  = 1'b1;
        fl_val = 4'b0001;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ret_q <= 4'd0;
      for (int i = 0; i < NREG; i++) rf[i] <= 4'd0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_RUN;
        S_RUN: begin
          if (op == OP_RET) begin
            state <= S_HALT;
            ret_q <= prm;
          end else begin
            rf[IX_IP] <= jump ? adr : ip + 4'd1;
            if (fl_en) rf[IX_STS] <= fl_val;
            if (wr_en) rf[wr_idx] <= wr_val;
          end
        end
        default: ;
      endcase
    end
  end

  assign imem_addr  = ip;
  assign dmem_addr  = adr + prm;
  assign dmem_wdata = rf[los];
  assign dmem_we    = run && (op == OP_STO);
  assign busy       = run;
  assign halted     = (state == S_HALT);
  assign ret_val    = ret_q;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !halted) |-> !dmem_we); // R1
  AST_WRITE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (busy && !halted)); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R3
  AST_RET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(ret_val) && $stable(imem_addr))); // R3
  AST_ALU_STEPS_IP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op >= OP_ADD && op <= OP_CMP) |=> (imem_addr == $past(imem_addr) + 4'd1)); // R2
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_CMP) |=> (acc == $past(acc))); // R7
  AST_JUMP_TO_ADR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_JMP && (prm & sts) != 4'd0) |=> (imem_addr == $past(adr))); // R10

endmodule

// File: tb/nibble_accum_core_tb.sv
module nibble_accum_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] imem_addr, dmem_addr, dmem_wdata, ret_val, dmem_rdata;
  logic [7:0] imem_data;
  logic       dmem_we, busy, halted;

  logic [7:0] rom [16];
  logic [3:0] ram [16];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign imem_data  = rom[imem_addr];
  assign dmem_rdata = ram[dmem_addr];
  always @(posedge clk) if (dmem_we) ram[dmem_addr] <= dmem_wdata;

  nibble_accum_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .busy(busy), .halted(halted), .ret_val(ret_val)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act %0d cycles exp completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) begin
      rom[i] = 8'h00;
      ram[i] = 4'h0;
    end
  endtask

  task automatic run_prog(output int n);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!halted && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    int n;
    clear_all();
    rom[0] = 8'h07;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 halted", halted, 0);
    check("R1 imem_addr", imem_addr, 0);
    check("R1 dmem_we", dmem_we, 0);
    run_prog(n);
    check("R3 halted", halted, 1);
    check("R3 ret_val", ret_val, 7);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R3 start ignored halted", halted, 1);
    check("R3 ret_val frozen", ret_val, 7);
    check("R3 ip frozen", imem_addr, 0);
  endtask

  task automatic t_arith();
    int n;
    clear_all();
    rom[0] = 8'h96; rom[1] = 8'hD5; rom[2] = 8'h9B; rom[3] = 8'h15;
    rom[4] = 8'hB0; rom[5] = 8'h25; rom[6] = 8'hB1; rom[7] = 8'h35;
    rom[8] = 8'hB2; rom[9] = 8'h9F; rom[10] = 8'h45; rom[11] = 8'hB3;
    rom[12] = 8'h75; rom[13] = 8'hB4; rom[14] = 8'h0A;
    run_prog(n);
    check("R4 add wrap", ram[0], 1);
    check("R4 sub wrap", ram[1], 11);
    check("R4 mul low nibble", ram[2], 2);
    check("R4 div", ram[3], 2);
    check("R5 xor", ram[4], 4);
    check("R3 ret", ret_val, 10);
  endtask

  task automatic t_logic();
    int n;
    clear_all();
    rom[0] = 8'h9C; rom[1] = 8'hD6; rom[2] = 8'h9A; rom[3] = 8'h56;
    rom[4] = 8'hB0; rom[5] = 8'h66; rom[6] = 8'hB1; rom[7] = 8'h95;
    rom[8] = 8'h76; rom[9] = 8'hB2; rom[10] = 8'h02;
    run_prog(n);
    check("R5 and", ram[0], 8);
    check("R5 orr", ram[1], 12);
    check("R5 xor", ram[2], 9);
    check("R2 one instr per cycle", n, 11);
  endtask

  task automatic t_flags_jump();
    int n;
    clear_all();
    rom[0] = 8'h98; rom[1] = 8'hD3; rom[2] = 8'h9F; rom[3] = 8'hD5;
    rom[4] = 8'h91; rom[5] = 8'h15; rom[6] = 8'hE2; rom[7] = 8'h0E;
    rom[8] = 8'hC1; rom[9] = 8'hB0; rom[10] = 8'hE0; rom[11] = 8'h05;
    run_prog(n);
    check("R6 add flags zero+carry", ram[8], 3);
    check("R10 carry jump taken", ret_val, 5);
  endtask

  task automatic t_cmp_zro();
    int n;
    clear_all();
    rom[0] = 8'h9C; rom[1] = 8'hD3; rom[2] = 8'h97; rom[3] = 8'hD6;
    rom[4] = 8'h93; rom[5] = 8'h86; rom[6] = 8'hC1; rom[7] = 8'hB0;
    rom[8] = 8'hEF; rom[9] = 8'hF1; rom[10] = 8'hEF; rom[11] = 8'h0E;
    rom[12] = 8'h09;
    run_prog(n);
    check("R7 cmp less flags", ram[12], 2);
    check("R10 zro STS then jmp 15", ret_val, 9);
  endtask

  task automatic t_divzero();
    int n;
    clear_all();
    rom[0] = 8'h99; rom[1] = 8'h48; rom[2] = 8'hB0; rom[3] = 8'hC1;
    rom[4] = 8'hB1; rom[5] = 8'h00;
    run_prog(n);
    check("R4 div by zero", ram[0], 15);
    check("R6 div zero flags", ram[1], 6);
  endtask

  task automatic t_loadstore();
    int n;
    clear_all();
    ram[2] = 4'hA;
    rom[0] = 8'h9D; rom[1] = 8'hD3; rom[2] = 8'h96; rom[3] = 8'hD7;
    rom[4] = 8'h97; rom[5] = 8'hD2; rom[6] = 8'hA5; rom[7] = 8'hB4;
    rom[8] = 8'h93; rom[9] = 8'hB6; rom[10] = 8'h90; rom[11] = 8'hF2;
    rom[12] = 8'hD1; rom[13] = 8'hC1; rom[14] = 8'hB0; rom[15] = 8'h03;
    run_prog(n);
    check("R8 ldm/sto via LOS wrap", ram[1], 10);
    check("R8 ldn into LOS reg", ram[3], 3);
    check("R11 explicit STS write wins", ram[13], 7);
    check("R9 ret", ret_val, 3);
  endtask

  task automatic t_ipwrite();
    int n;
    clear_all();
    rom[0] = 8'hC5; rom[1] = 8'hE4; rom[2] = 8'h96; rom[3] = 8'hD3;
    rom[4] = 8'h9E; rom[5] = 8'hD4; rom[6] = 8'h08; rom[7] = 8'h01;
    rom[14] = 8'h99; rom[15] = 8'hD5;
    run_prog(n);
    check("R11 IP write and R2 wrap", ret_val, 8);
    check("R9 mva path cycles", n, 11);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_flags_jump();
    t_cmp_zro();
    t_divzero();
    t_loadstore();
    t_ipwrite();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule